// File: doc/BRIEF.md
# Configurable PLD Macrocell

This block is one logic cell of a product-term programmable device. A static configuration word selects which true or inverted signals of a local input bus feed each of five AND terms. It also routes every term either into a sum path or to one of the storage element's control functions. The sum goes through a polarity XOR and then either directly to the output or through a D/T flip-flop.

The same output drives the external interconnect port and the local feedback port. The cell also offers one of its terms, inverted, as a shareable expander for its neighbours. It joins a parallel expander chain: it can absorb the incoming chain sum into its own logic, or lend terms onward to the next cell.

The design runs on one system clock. The selected macrocell clock (a global clock or a product term) is sampled every system cycle, and a rising edge on it triggers a load. Clear and preset act on the next system cycle whether or not a macrocell clock edge occurs.

Top module: `mc_macrocell`

## Requirements
- R1: The local bus is indexed with row inputs at 0..32, local feedbacks at 33..48 and shareable expander lines at 49..64. Term t (0..4) is the AND of the literals its mask selects. Bit 25+130*t+2*i selects bus bit i in true form, and the next bit up selects it inverted. A term with no literal selected is 0.
- R2: Each term has a 3-bit steering code at config bits 10+3*t. Code 0 ORs the term into the sum. Codes 6 and 7 discard the term.
- R3: Config bit 6 set inverts the sum before the bypass/register stage.
- R4: With config bit 4 set, the output shows the XOR result in the same cycle. The feedback port always equals the output port.
- R5: With config bit 5 clear, the register loads the XOR result in the system cycle where the selected clock source is 1 and was 0 at the previous system clock edge. Otherwise it holds.
- R6: With config bit 5 set, the register toggles on such an edge when the XOR result is 1, and holds when it is 0.
- R7: Clock source bits 3:2 select the source: 0 picks global clock 0, 1 picks global clock 1, 2 and 3 pick the OR of terms with code 3. With no code-3 term the register never clocks.
- R8: Enable is the OR of terms with code 4, or 1 when no term carries code 4. With enable 0 a clock edge does not load.
- R9: Preset is the OR of code-2 terms. Clear is the global clear when config bit 1 is 0, and the OR of code-1 terms when it is 1. Clear wins over preset, and both win over clocking and enable. Each takes effect at the next system clock edge.
- R10: Config bits 9:7 pick a term index. The shareable output is that term inverted, or 1 for an index above 4.
- R11: Code-5 terms are lent and ORed into the chain output. The chain input is ORed into the sum when config bit 0 is 0, and is passed to the chain output instead when it is 1.
- R12: Synchronous reset clears the register and the clock edge history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| cfg | input | 675 | static configuration word |
| row_in | input | 33 | row interconnect inputs |
| lfb_in | input | 16 | local feedback inputs |
| shx_in | input | 16 | shareable expander lines in |
| gclk | input | 2 | global clocks |
| gclr | input | 1 | global clear, active high |
| pexp_in | input | 1 | parallel expander chain in |
| mc_out | output | 1 | output to interconnect |
| lfb_out | output | 1 | feedback to local array |
| sexp_out | output | 1 | inverted shared term |
| pexp_out | output | 1 | parallel expander chain out |

## Verification
The bench targets the cases where control routing is easy to get wrong. An empty term must read 0, or it would turn into a stuck-on sum or a free-running clock. A term with no clock assignment must leave the register frozen. Enable must default to 1 only while no term is steered to it, or the register never loads. Clear must win over a simultaneous preset and over a clock edge, or the output would come up 1. The chain bit must move the incoming sum between the cell's own output and the chain output, not to both. Random configurations in bypass mode are compared with an independent model of the term, sum and expander logic.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam int STEER_W = 3;

  typedef enum logic [STEER_W-1:0] {
    ST_SUM  = 3'd0,
    ST_CLR  = 3'd1,
    ST_PRE  = 3'd2,
    ST_CLK  = 3'd3,
    ST_ENA  = 3'd4,
    ST_LEND = 3'd5,
    ST_NC6  = 3'd6,
    ST_NC7  = 3'd7
  } steer_e;

  typedef struct packed {
    logic clr;
    logic pre;
    logic clk;
    logic ena;
    logic ena_used;
  } ctl_t;

  function automatic int sel_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/mc_and_array.sv
module mc_and_array #(
  parameter int NIN = 65,
  parameter int NPT = 5
) (
  input  logic [NIN-1:0]       bus,
  input  logic [NPT*2*NIN-1:0] mask,
  output logic [NPT-1:0]       pt
);
  localparam int LW = 2 * NIN;

  logic [LW-1:0] lit;

  always_comb begin
    for (int i = 0; i < NIN; i++) begin
      lit[2*i]   = bus[i];
      lit[2*i+1] = ~bus[i];
    end
  end

  for (genvar t = 0; t < NPT; t++) begin : g_term
    logic [LW-1:0] sel;
    assign sel   = mask[t*LW +: LW];
    // an unprogrammed term must not read as a constant 1
    assign pt[t] = (|sel) & (&(lit | ~sel));
  end
endmodule

// File: rtl/mc_pt_steer.sv
module mc_pt_steer
  import mc_pkg::*;
#(
  parameter int NPT = 5,
  parameter int SW  = 3
) (
  input  logic [NPT-1:0]         pt,
  input  logic [NPT*STEER_W-1:0] steer,
  input  logic [SW-1:0]          sexp_sel,
  input  logic                   pexp_in,
  input  logic                   chain_pass,
  output logic                   sum,
  output ctl_t                   ctl,
  output logic                   sexp_out,
  output logic                   pexp_out
);
  logic [NPT-1:0] to_sum, to_clr, to_pre, to_clk, to_ena, to_lend, has_ena;

  for (genvar t = 0; t < NPT; t++) begin : g_route
    steer_e code;
    assign code       = steer_e'(steer[t*STEER_W +: STEER_W]);
    assign to_sum[t]  = pt[t] & (code == ST_SUM);
    assign to_clr[t]  = pt[t] & (code == ST_CLR);
    assign to_pre[t]  = pt[t] & (code == ST_PRE);
    assign to_clk[t]  = pt[t] & (code == ST_CLK);
    assign to_ena[t]  = pt[t] & (code == ST_ENA);
    assign to_lend[t] = pt[t] & (code == ST_LEND);
    assign has_ena[t] = (code == ST_ENA);
  end

  assign sum          = (|to_sum) | (pexp_in & ~chain_pass);
  assign pexp_out     = (|to_lend) | (pexp_in & chain_pass);
  assign ctl.clr      = |to_clr;
  assign ctl.pre      = |to_pre;
  assign ctl.clk      = |to_clk;
  assign ctl.ena      = |to_ena;
  assign ctl.ena_used = |has_ena;

  always_comb begin
    sexp_out = 1'b1;
    for (int t = 0; t < NPT; t++) begin
      if (sexp_sel == SW'(t)) sexp_out = ~pt[t];
    end
  end
endmodule

// File: rtl/mc_storage.sv
module mc_storage
  import mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] clk_src,
  input  logic [1:0] gclk,
  input  logic       clr_src,
  input  logic       gclr,
  input  ctl_t       ctl,
  input  logic       t_mode,
  input  logic       din,
  output logic       q,
  output logic       clk_edge,
  output logic       clr_act,
  output logic       pre_act,
  output logic       ena_act
);
  logic src, src_q;

  always_comb begin
    case (clk_src)
      2'd0:    src = gclk[0];
      2'd1:    src = gclk[1];
      default: src = ctl.clk;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) src_q <= 1'b0;
    else     src_q <= src;
  end

  assign clk_edge = src & ~src_q;
  assign clr_act  = clr_src ? ctl.clr : gclr;
  assign pre_act  = ctl.pre;
  assign ena_act  = ctl.ena_used ? ctl.ena : 1'b1;

  always_ff @(posedge clk) begin
    if (rst)                       q <= 1'b0;
    else if (clr_act)              q <= 1'b0;
    else if (pre_act)              q <= 1'b1;
    else if (clk_edge && ena_act)  q <= t_mode ? (q ^ din) : din;
  end
endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
  import mc_pkg::*;
#(
  parameter int NROW = 33,
  parameter int NFB  = 16,
  parameter int NSX  = 16,
  parameter int NPT  = 5,
  localparam int NIN     = NROW + NFB + NSX,
  localparam int SW      = mc_pkg::sel_width(NPT),
  localparam int O_SEL   = 7,
  localparam int O_STEER = O_SEL + SW,
  localparam int O_MASK  = O_STEER + NPT * mc_pkg::STEER_W,
  localparam int CFG_W   = O_MASK + NPT * 2 * NIN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg,
  input  logic [NROW-1:0]  row_in,
  input  logic [NFB-1:0]   lfb_in,
  input  logic [NSX-1:0]   shx_in,
  input  logic [1:0]       gclk,
  input  logic             gclr,
  input  logic             pexp_in,
  output logic             mc_out,
  output logic             lfb_out,
  output logic             sexp_out,
  output logic             pexp_out
);
  logic       chain_pass, clr_src, byp, t_mode, inv;
  logic [1:0] clk_src;
  logic [SW-1:0] sexp_sel;
  logic [NIN-1:0] bus;
  logic [NPT-1:0] pt;
  logic sum, xr, reg_q, clk_edge, clr_act, pre_act, ena_act;
  ctl_t ctl;

  assign chain_pass = cfg[0];
  assign clr_src    = cfg[1];
  assign clk_src    = cfg[3:2];
  assign byp        = cfg[4];
  assign t_mode     = cfg[5];
  assign inv        = cfg[6];
  assign sexp_sel   = cfg[O_SEL +: SW];
  assign bus        = {shx_in, lfb_in, row_in};

  mc_and_array #(.NIN(NIN), .NPT(NPT)) and_i (
    .bus  (bus),
    .mask (cfg[O_MASK +: NPT*2*NIN]),
    .pt   (pt)
  );

  mc_pt_steer #(.NPT(NPT), .SW(SW)) steer_i (
    .pt         (pt),
    .steer      (cfg[O_STEER +: NPT*STEER_W]),
    .sexp_sel   (sexp_sel),
    .pexp_in    (pexp_in),
    .chain_pass (chain_pass),
    .sum        (sum),
    .ctl        (ctl),
    .sexp_out   (sexp_out),
    .pexp_out   (pexp_out)
  );

  assign xr = sum ^ inv;

  mc_storage reg_i (
    .clk      (clk),
    .rst      (rst),
    .clk_src  (clk_src),
    .gclk     (gclk),
    .clr_src  (clr_src),
    .gclr     (gclr),
    .ctl      (ctl),
    .t_mode   (t_mode),
    .din      (xr),
    .q        (reg_q),
    .clk_edge (clk_edge),
    .clr_act  (clr_act),
    .pre_act  (pre_act),
    .ena_act  (ena_act)
  );

  assign mc_out  = byp ? xr : reg_q;
  assign lfb_out = mc_out;
endmodule

// File: rtl/mc_macrocell_chk.sv
module mc_macrocell_chk (
  input logic clk,
  input logic rst,
  input logic clr_src,
  input logic gclr,
  input logic t_mode,
  input logic clk_edge,
  input logic clr_act,
  input logic pre_act,
  input logic ena_act,
  input logic din,
  input logic reg_q
);
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr_act |=> !reg_q); // R9
  AST_PRESET_SETS: assert property (@(posedge clk) disable iff (rst)
    (pre_act && !clr_act) |=> reg_q); // R9
  AST_GLOBAL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!clr_src && gclr) |=> !reg_q); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!clr_act && !pre_act && !(clk_edge && ena_act)) |=> $stable(reg_q)); // R5
  AST_D_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!t_mode && clk_edge && ena_act && !clr_act && !pre_act) |=> (reg_q == $past(din))); // R5
  AST_T_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (t_mode && clk_edge && ena_act && din && !clr_act && !pre_act) |=> (reg_q != $past(reg_q))); // R6
endmodule

bind mc_macrocell mc_macrocell_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .clr_src  (clr_src),
  .gclr     (gclr),
  .t_mode   (t_mode),
  .clk_edge (clk_edge),
  .clr_act  (clr_act),
  .pre_act  (pre_act),
  .ena_act  (ena_act),
  .din      (xr),
  .reg_q    (reg_q)
);

// File: tb/mc_macrocell_tb_top.sv
`timescale 1ns/1ps
module mc_macrocell_tb_top;
  localparam int NIN = 65;
  localparam int NPT = 5;
  localparam int SO  = 10;
  localparam int MO  = 25;
  localparam int CW  = MO + NPT * 2 * NIN;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] cfg = '0;
  logic [32:0] row_in = '0;
  logic [15:0] lfb_in = '0;
  logic [15:0] shx_in = '0;
  logic [1:0]  gclk = 2'b00;
  logic gclr = 1'b0;
  logic pexp_in = 1'b0;
  logic mc_out, lfb_out, sexp_out, pexp_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mc_macrocell dut_i (
    .clk(clk), .rst(rst), .cfg(cfg), .row_in(row_in), .lfb_in(lfb_in),
    .shx_in(shx_in), .gclk(gclk), .gclr(gclr), .pexp_in(pexp_in),
    .mc_out(mc_out), .lfb_out(lfb_out), .sexp_out(sexp_out), .pexp_out(pexp_out)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // configuration helpers, field positions as stated in the requirements
  task automatic c_new();
    cfg = '0;
    for (int t = 0; t < NPT; t++) cfg[SO+3*t +: 3] = 3'd6;
  endtask
  task automatic c_lit(input int t, input int i, input bit neg);
    cfg[MO + t*2*NIN + 2*i + (neg ? 1 : 0)] = 1'b1;
  endtask
  task automatic c_code(input int t, input int code);
    cfg[SO+3*t +: 3] = 3'(code);
  endtask

  task automatic set_bus(input logic [NIN-1:0] b);
    row_in = b[32:0];
    lfb_in = b[48:33];
    shx_in = b[64:49];
  endtask

  task automatic pulse_g(input int k);
    @(negedge clk); gclk[k] = 1'b1;
    @(negedge clk); gclk[k] = 1'b0;
  endtask

  task automatic pulse_row(input int i);
    @(negedge clk); row_in[i] = 1'b1;
    @(negedge clk); row_in[i] = 1'b0;
  endtask

  // independent model of terms, sum and expanders
  function automatic logic m_term(input logic [CW-1:0] c, input logic [NIN-1:0] b, input int t);
    logic any = 1'b0;
    logic r = 1'b1;
    for (int i = 0; i < NIN; i++) begin
      if (c[MO+t*2*NIN+2*i])   begin any = 1'b1; r = r & b[i];  end
      if (c[MO+t*2*NIN+2*i+1]) begin any = 1'b1; r = r & ~b[i]; end
    end
    return any & r;
  endfunction

  function automatic logic m_or(input logic [CW-1:0] c, input logic [NIN-1:0] b, input int code);
    logic r = 1'b0;
    for (int t = 0; t < NPT; t++)
      if (int'(c[SO+3*t +: 3]) == code) r = r | m_term(c, b, t);
    return r;
  endfunction

  function automatic logic m_out(input logic [CW-1:0] c, input logic [NIN-1:0] b, input logic pin);
    return (m_or(c, b, 0) | (pin & ~c[0])) ^ c[6];
  endfunction

  function automatic logic m_sexp(input logic [CW-1:0] c, input logic [NIN-1:0] b);
    int s = int'(c[9:7]);
    return (s < NPT) ? ~m_term(c, b, s) : 1'b1;
  endfunction

  function automatic logic m_pexp(input logic [CW-1:0] c, input logic [NIN-1:0] b, input logic pin);
    return m_or(c, b, 5) | (pin & c[0]);
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    c_new(); c_lit(3, 9, 0); c_code(3, 2);
    rst = 1'b0; row_in[9] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R9 preset before reset", mc_out, 1'b1);
    row_in[9] = 1'b0;
    do_reset();
    chk("R12 register cleared by reset", mc_out, 1'b0);
    chk("R4 feedback after reset", lfb_out, 1'b0);
  endtask

  task automatic t_terms();
    c_new(); cfg[4] = 1'b1;
    c_lit(0, 0, 0); c_lit(0, 36, 1); c_code(0, 0);   // row0 & ~fb3
    c_lit(1, 1, 0); c_code(1, 6);                   // discarded
    c_code(2, 0);                                   // empty term in sum
    c_lit(3, 60, 0); c_code(3, 7);                  // discarded
    set_bus('0); row_in[0] = 1'b1; #1;
    chk("R1 true and inverted literal", mc_out, 1'b1);
    lfb_in[3] = 1'b1; #1;
    chk("R1 inverted literal blocks", mc_out, 1'b0);
    lfb_in[3] = 1'b0; row_in[0] = 1'b0; row_in[1] = 1'b1; shx_in[11] = 1'b1; #1;
    chk("R2 codes 6 and 7 ignored, empty term is 0", mc_out, 1'b0);
    chk("R4 feedback equals output", lfb_out, mc_out);
    c_code(1, 0); #1;
    chk("R2 code 0 joins sum", mc_out, 1'b1);
  endtask

  task automatic t_polarity();
    c_new(); cfg[4] = 1'b1; cfg[6] = 1'b1;
    c_lit(0, 2, 0); c_code(0, 0);
    set_bus('0); #1;
    chk("R3 inverted zero sum", mc_out, 1'b1);
    row_in[2] = 1'b1; #1;
    chk("R3 inverted one sum", mc_out, 1'b0);
  endtask

  task automatic t_dreg();
    c_new(); c_lit(0, 0, 0); c_code(0, 0);
    set_bus('0); do_reset();
    row_in[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R5 no load without edge", mc_out, 1'b0);
    pulse_g(0);
    chk("R5 load on rising edge", mc_out, 1'b1);
    chk("R4 feedback follows register", lfb_out, 1'b1);
    row_in[0] = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R5 hold between edges", mc_out, 1'b1);
    pulse_g(0);
    chk("R5 load zero", mc_out, 1'b0);
  endtask

  task automatic t_treg();
    c_new(); cfg[5] = 1'b1; c_lit(0, 0, 0); c_code(0, 0);
    set_bus('0); do_reset();
    row_in[0] = 1'b1;
    pulse_g(0);
    chk("R6 toggle to 1", mc_out, 1'b1);
    pulse_g(0);
    chk("R6 toggle to 0", mc_out, 1'b0);
    pulse_g(0);
    row_in[0] = 1'b0;
    pulse_g(0);
    chk("R6 hold with T=0", mc_out, 1'b1);
  endtask

  task automatic t_clksel();
    c_new(); cfg[3:2] = 2'd1; c_lit(0, 0, 0); c_code(0, 0);
    set_bus('0); do_reset();
    row_in[0] = 1'b1;
    pulse_g(0);
    chk("R7 unselected clock ignored", mc_out, 1'b0);
    pulse_g(1);
    chk("R7 global clock 1 loads", mc_out, 1'b1);
    cfg[3:2] = 2'd2; c_lit(1, 5, 0); c_code(1, 3);
    do_reset(); row_in[0] = 1'b1;
    pulse_row(5);
    chk("R7 product-term clock loads", mc_out, 1'b1);
    cfg[3:2] = 2'd3; c_code(1, 6);
    do_reset(); row_in[0] = 1'b1;
    pulse_row(5); pulse_g(0); pulse_g(1);
    chk("R7 no clock term never clocks", mc_out, 1'b0);
  endtask

  task automatic t_enable();
    c_new(); c_lit(0, 0, 0); c_code(0, 0); c_lit(2, 7, 0); c_code(2, 4);
    set_bus('0); do_reset();
    row_in[0] = 1'b1;
    pulse_g(0);
    chk("R8 enable term low blocks load", mc_out, 1'b0);
    row_in[7] = 1'b1;
    pulse_g(0);
    chk("R8 enable term high allows load", mc_out, 1'b1);
  endtask

  task automatic t_clrpre();
    c_new(); cfg[1] = 1'b1;
    c_lit(0, 0, 0); c_code(0, 0);
    c_lit(3, 9, 0); c_code(3, 2);
    c_lit(4, 10, 0); c_code(4, 1);
    set_bus('0); do_reset();
    @(negedge clk); row_in[9] = 1'b1;
    @(negedge clk);
    chk("R9 preset term sets", mc_out, 1'b1);
    row_in[10] = 1'b1;
    @(negedge clk);
    chk("R9 clear wins over preset", mc_out, 1'b0);
    row_in[9] = 1'b0; row_in[0] = 1'b1;
    pulse_g(0);
    chk("R9 clear wins over clock", mc_out, 1'b0);
    row_in[10] = 1'b0;
    gclr = 1'b1;
    pulse_g(0);
    chk("R9 global clear unused when term clear chosen", mc_out, 1'b1);
    cfg[1] = 1'b0; row_in[10] = 1'b1;
    @(negedge clk);
    chk("R9 global clear selected", mc_out, 1'b0);
    gclr = 1'b0;
    pulse_g(0);
    chk("R9 clear term ignored with global source", mc_out, 1'b1);
    row_in[10] = 1'b0;
  endtask

  task automatic t_sexp();
    c_new(); cfg[9:7] = 3'd2; c_lit(2, 3, 0); c_code(2, 6);
    set_bus('0); #1;
    chk("R10 shared term low gives 1", sexp_out, 1'b1);
    row_in[3] = 1'b1; #1;
    chk("R10 shared term high gives 0", sexp_out, 1'b0);
    cfg[9:7] = 3'd6; #1;
    chk("R10 index above range gives 1", sexp_out, 1'b1);
  endtask

  task automatic t_chain();
    c_new(); cfg[4] = 1'b1;
    c_lit(0, 0, 0); c_code(0, 0); c_lit(1, 1, 0); c_code(1, 5);
    set_bus('0); pexp_in = 1'b1; #1;
    chk("R11 chain absorbed into sum", mc_out, 1'b1);
    chk("R11 chain not forwarded", pexp_out, 1'b0);
    row_in[1] = 1'b1; pexp_in = 1'b0; #1;
    chk("R11 lent term exported", pexp_out, 1'b1);
    chk("R11 lent term not in sum", mc_out, 1'b0);
    row_in[1] = 1'b0; pexp_in = 1'b1; cfg[0] = 1'b1; #1;
    chk("R11 chain forwarded", pexp_out, 1'b1);
    chk("R11 forwarded chain not in sum", mc_out, 1'b0);
    pexp_in = 1'b0;
  endtask

  task automatic t_random();
    for (int n = 0; n < 150; n++) begin
      c_new(); cfg[4] = 1'b1;
      cfg[0] = 1'($urandom_range(1));
      cfg[6] = 1'($urandom_range(1));
      cfg[9:7] = 3'($urandom_range(7));
      for (int t = 0; t < NPT; t++) begin
        c_code(t, $urandom_range(7));
        for (int i = 0; i < 2*NIN; i++)
          if ($urandom_range(45) == 0) cfg[MO + t*2*NIN + i] = 1'b1;
      end
      for (int k = 0; k < 3; k++) begin
        logic [NIN-1:0] b;
        logic pin;
        b = {$urandom, $urandom, $urandom};
        pin = 1'($urandom_range(1));
        set_bus(b); pexp_in = pin; #1;
        chk("R1 R2 R3 random sum", mc_out, m_out(cfg, b, pin));
        chk("R10 random shared term", sexp_out, m_sexp(cfg, b));
        chk("R11 random chain", pexp_out, m_pexp(cfg, b, pin));
      end
    end
    pexp_in = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    t_terms();
    t_polarity();
    t_dreg();
    t_treg();
    t_clksel();
    t_enable();
    t_clrpre();
    t_sexp();
    t_chain();
    t_random();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule